// File: doc/BRIEF.md
# Programmable Vertical Pulse Pattern Generator

This block drives a bus of vertical clock waveforms for an image-sensor timing path. A shared position counter restarts on every falling edge of the horizontal sync input, and each output channel compares that position against four toggle points of its own. A toggle point is measured from a common start offset. Each match inverts the channel's level. A common pattern length can make the pattern repeat inside one line. At each repetition boundary every channel returns to its own start polarity.

A channel can be put in sensor-gate mode. In that mode only one pair of its toggle points is active, and a select bit picks which pair. Configuration is written through a simple address/data port into staging registers. The active copy is loaded only at the next horizontal sync falling edge, so a write never changes a waveform in the middle of a line.

Top module: `vpat_gen`

## Requirements
- R1: After reset every output is 0, the counter is idle, and the outputs do not change until the first hsync falling edge (hsync sampled high at one clock edge and low at the next).
- R2: The clock edge that samples the hsync fall defines pixel 0. After that edge each output equals the polarity of its channel. A toggle at absolute pixel P becomes visible after the (P+1)-th edge that follows it.
- R3: The absolute pixel of a toggle is the start offset plus the toggle value. Before the start offset each output holds its polarity.
- R4: Each of the four toggle values inverts the output when it matches. A value of 0, a value of all ones (8191), or a value not less than the pattern length is ignored, so a channel programmed only with 0 or 8191 stays constant.
- R5: With repeat set and a non-zero length, the counter jumps back to the start offset after absolute pixel start+length-1, and every output returns to its polarity, so the pattern repeats every length pixels. With repeat clear the pattern runs once and the last level is held.
- R6: In sensor-gate mode only toggles 1 and 2 act when the select bit is 0, and only toggles 3 and 4 act when it is 1.
- R7: Writes go to staging registers. The outputs follow the old configuration until the next hsync falling edge, and the new one applies from that edge on.
- R8: Address map: wr_addr[7:3] is the channel (0 to 23) and wr_addr[2:0] picks the field. Values 0 to 3 select toggles 1 to 4. Value 4 selects control, with bit0 = polarity, bit1 = gate mode and bit2 = pair select. Channel 24 holds the common fields: field 0 = start offset, 1 = length, 2 = bit0 repeat. Any other address is ignored.
- R9: An hsync falling edge in the middle of a pattern restarts the line at pixel 0 and reloads the configuration.
- R10: Several toggles of one channel that match the same pixel invert the output only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync; its falling edge starts a line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address (channel, field) |
| wr_data | input | 13 | Write data |
| vout | output | 24 | Registered vertical outputs, one bit per channel |

## Verification
The bench targets the pixel where each toggle lands. A design that forgot to add the start offset, or that has an extra register, would put every edge one or more pixels off. Wrap tests use a high start polarity. A design that fails to restore polarity at the repetition boundary would then run the second repetition inverted. Other cases are aimed at specific faults:
- Gate-mode channels carry all four toggles, so a wrong pair select shows up as extra edges.
- Duplicate toggles and the 0, 8191 and beyond-length values expose a decoder that toggles twice or treats a disabled value as a real one.
- Writes made in the middle of a line and a spurious out-of-range address catch staging that leaks into the active copy, or address decoding that aliases.

// File: rtl/vpat_pkg.sv
package vpat_pkg;
  timeunit 1ns; timeprecision 1ps;
  // field codes inside a channel slot (wr_addr[2:0])
  localparam logic [2:0] FLD_TOG1  = 3'd0;
  localparam logic [2:0] FLD_TOG4  = 3'd3;
  localparam logic [2:0] FLD_CTRL  = 3'd4;
  // field codes inside the common slot
  localparam logic [2:0] FLD_START = 3'd0;
  localparam logic [2:0] FLD_LEN   = 3'd1;
  localparam logic [2:0] FLD_MODE  = 3'd2;
  localparam int NUM_TOG = 4;
endpackage

// File: rtl/vpat_regs.sv
module vpat_regs
  import vpat_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int POS_W  = 13,
  parameter int CH_W   = 5
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [CH_W+2:0]                           wr_addr,
  input  logic [POS_W-1:0]                          wr_data,
  output logic [NUM_CH-1:0][NUM_TOG-1:0][POS_W-1:0] sh_tog,
  output logic [NUM_CH-1:0]                         sh_pol,
  output logic [NUM_CH-1:0]                         sh_gate,
  output logic [NUM_CH-1:0]                         sh_sel,
  output logic [POS_W-1:0]                          sh_start,
  output logic [POS_W-1:0]                          sh_len,
  output logic                                      sh_rep
);
  logic [CH_W-1:0] wr_ch;
  logic [2:0]      wr_fld;
  assign wr_ch  = wr_addr[CH_W+2:3];
  assign wr_fld = wr_addr[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_tog   <= '0;
      sh_pol   <= '0;
      sh_gate  <= '0;
      sh_sel   <= '0;
      sh_start <= '0;
      sh_len   <= '0;
      sh_rep   <= 1'b0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_ch == CH_W'(c)) begin
          if (wr_fld <= FLD_TOG4)
            sh_tog[c][wr_fld[1:0]] <= wr_data;
          else if (wr_fld == FLD_CTRL) begin
            sh_pol[c]  <= wr_data[0];
            sh_gate[c] <= wr_data[1];
            sh_sel[c]  <= wr_data[2];
          end
        end
      end
      if (wr_ch == CH_W'(NUM_CH)) begin
        case (wr_fld)
          FLD_START: sh_start <= wr_data;
          FLD_LEN:   sh_len   <= wr_data;
          FLD_MODE:  sh_rep   <= wr_data[0];
          default:   ;
        endcase
      end
    end
  end

  // R8: writes beyond the common slot leave every staging register alone
  p_bad_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_ch > CH_W'(NUM_CH))) |=>
      ($stable(sh_tog) && $stable(sh_pol) && $stable(sh_gate) && $stable(sh_sel)
       && $stable(sh_start) && $stable(sh_len) && $stable(sh_rep)));
endmodule

// File: rtl/vpat_counter.sv
module vpat_counter #(
  parameter int POS_W = 13,
  localparam int PW   = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync,
  input  logic [POS_W-1:0] sh_start,
  input  logic [POS_W-1:0] sh_len,
  input  logic             sh_rep,
  output logic             fall,
  output logic             running,
  output logic             wrap,
  output logic [PW-1:0]    pos,
  output logic [POS_W-1:0] act_start,
  output logic [POS_W-1:0] act_len
);
  logic          hs_d;
  logic          act_rep;
  logic [PW-1:0] end_pos;

  assign fall    = hs_d & ~hsync;
  assign end_pos = {1'b0, act_start} + {1'b0, act_len} - PW'(1);
  assign wrap    = running && act_rep && (act_len != '0) && (pos == end_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d      <= 1'b0;
      running   <= 1'b0;
      pos       <= '0;
      act_start <= '0;
      act_len   <= '0;
      act_rep   <= 1'b0;
    end else begin
      hs_d <= hsync;
      if (fall) begin
        running   <= 1'b1;
        pos       <= '0;
        act_start <= sh_start;
        act_len   <= sh_len;
        act_rep   <= sh_rep;
      end else if (running) begin
        if (wrap)
          pos <= {1'b0, act_start};
        else if (pos != '1)
          pos <= pos + PW'(1);
      end
    end
  end

  // R2: a sync fall restarts the count at pixel 0
  p_fall_zero_r2: assert property (@(posedge clk) disable iff (rst)
    fall |=> (pos == '0) && running);
  // R5: the wrap point sends the counter back to the start offset
  p_wrap_start_r5: assert property (@(posedge clk) disable iff (rst)
    (wrap && !fall) |=> (pos == {1'b0, act_start}));
  // R7: the active common fields change only at a sync fall
  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (rst)
    !fall |=> ($stable(act_start) && $stable(act_len) && $stable(act_rep)));
endmodule

// File: rtl/vpat_channel.sv
module vpat_channel
  import vpat_pkg::*;
#(
  parameter int POS_W = 13,
  localparam int PW   = POS_W + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           fall,
  input  logic                           running,
  input  logic                           wrap,
  input  logic [PW-1:0]                  pos,
  input  logic [POS_W-1:0]               act_start,
  input  logic [POS_W-1:0]               act_len,
  input  logic [NUM_TOG-1:0][POS_W-1:0]  sh_tog,
  input  logic                           sh_pol,
  input  logic                           sh_gate,
  input  logic                           sh_sel,
  output logic                           lvl
);
  logic [NUM_TOG-1:0][POS_W-1:0] a_tog;
  logic                          a_pol, a_gate, a_sel;
  logic [PW-1:0]                 rel;
  logic                          in_pat, hit, all_off;

  always_comb begin
    logic en_k, ok_k;
    rel     = pos - {1'b0, act_start};
    in_pat  = pos >= {1'b0, act_start};
    hit     = 1'b0;
    all_off = 1'b1;
    for (int k = 0; k < NUM_TOG; k++) begin
      en_k = a_gate ? (a_sel ? (k >= 2) : (k < 2)) : 1'b1;
      ok_k = (a_tog[k] != '0) && (a_tog[k] != '1) && (a_tog[k] < act_len);
      if (a_tog[k] != '0 && a_tog[k] != '1) all_off = 1'b0;
      if (en_k && ok_k && in_pat && (rel == {1'b0, a_tog[k]})) hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_tog  <= '0;
      a_pol  <= 1'b0;
      a_gate <= 1'b0;
      a_sel  <= 1'b0;
      lvl    <= 1'b0;
    end else if (fall) begin
      a_tog  <= sh_tog;
      a_pol  <= sh_pol;
      a_gate <= sh_gate;
      a_sel  <= sh_sel;
      lvl    <= sh_pol;
    end else if (running) begin
      if (wrap)     lvl <= a_pol;
      else if (hit) lvl <= ~lvl;
    end
  end

  // R1: no activity before the first sync fall
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!running && !fall) |=> $stable(lvl));
  // R2: a sync fall loads the staged polarity
  p_fall_pol_r2: assert property (@(posedge clk) disable iff (rst)
    fall |=> (lvl == $past(sh_pol)));
  // R3: the level is held ahead of the start offset
  p_pre_start_r3: assert property (@(posedge clk) disable iff (rst)
    (running && !fall && !wrap && (pos < {1'b0, act_start})) |=> $stable(lvl));
  // R4: a channel with only disabled toggle codes never moves inside a line
  p_unused_r4: assert property (@(posedge clk) disable iff (rst)
    (all_off && !fall && !wrap) |=> $stable(lvl));
endmodule

// File: rtl/vpat_gen.sv
module vpat_gen
  import vpat_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int POS_W  = 13,
  localparam int CH_W  = $clog2(NUM_CH + 1),
  localparam int AW    = CH_W + 3,
  localparam int PW    = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [POS_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] vout
);
  timeunit 1ns; timeprecision 1ps;

  logic [NUM_CH-1:0][NUM_TOG-1:0][POS_W-1:0] sh_tog;
  logic [NUM_CH-1:0] sh_pol, sh_gate, sh_sel;
  logic [POS_W-1:0]  sh_start, sh_len, act_start, act_len;
  logic              sh_rep, fall, running, wrap;
  logic [PW-1:0]     pos;
  logic [NUM_CH-1:0] lvl;

  vpat_regs #(.NUM_CH(NUM_CH), .POS_W(POS_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sh_tog(sh_tog), .sh_pol(sh_pol), .sh_gate(sh_gate), .sh_sel(sh_sel),
    .sh_start(sh_start), .sh_len(sh_len), .sh_rep(sh_rep));

  vpat_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst(rst), .hsync(hsync), .sh_start(sh_start), .sh_len(sh_len),
    .sh_rep(sh_rep), .fall(fall), .running(running), .wrap(wrap), .pos(pos),
    .act_start(act_start), .act_len(act_len));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vpat_channel #(.POS_W(POS_W)) u_ch (
      .clk(clk), .rst(rst), .fall(fall), .running(running), .wrap(wrap),
      .pos(pos), .act_start(act_start), .act_len(act_len),
      .sh_tog(sh_tog[c]), .sh_pol(sh_pol[c]), .sh_gate(sh_gate[c]),
      .sh_sel(sh_sel[c]), .lvl(lvl[c]));
  end

  assign vout = lvl;
endmodule

// File: tb/tb_vpat_gen.sv
module tb_vpat_gen;
  timeunit 1ns; timeprecision 1ps;
  localparam int NCH = 24;
  localparam int MAXV = 8191;

  logic clk = 1'b0, rst = 1'b1, hsync = 1'b0, wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [12:0]   wr_data = '0;
  logic [NCH-1:0] vout;

  vpat_gen dut (.clk(clk), .rst(rst), .hsync(hsync), .wr_en(wr_en),
                .wr_addr(wr_addr), .wr_data(wr_data), .vout(vout));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cur_k = 0;
  bit done = 0;
  int s_tog[NCH][4], a_tog[NCH][4];
  bit s_pol[NCH], s_gate[NCH], s_sel[NCH], a_pol[NCH], a_gate[NCH], a_sel[NCH];
  int s_start = 0, s_len = 0, a_start = 0, a_len = 0;
  bit s_rep = 0, a_rep = 0;

  function automatic bit tog_live(int ch, int k, int v);
    if (a_gate[ch] && (a_sel[ch] ? (k < 2) : (k >= 2))) return 0;
    return (v != 0) && (v != MAXV) && (v < a_len);
  endfunction

  // level of one channel after k edges past the pixel-0 edge
  function automatic bit model_lvl(int ch, int k);
    bit l = a_pol[ch];
    int p = 0;
    for (int i = 0; i < k; i++) begin
      if (a_rep && a_len != 0 && p == a_start + a_len - 1) begin
        l = a_pol[ch]; p = a_start;
      end else begin
        bit m = 0;
        for (int t = 0; t < 4; t++)
          if (p >= a_start && tog_live(ch, t, a_tog[ch][t]) && p - a_start == a_tog[ch][t]) m = 1;
        if (m) l = ~l;
        p++;
      end
    end
    return l;
  endfunction

  function automatic logic [NCH-1:0] model_bus(int k);
    logic [NCH-1:0] b;
    for (int c = 0; c < NCH; c++) b[c] = model_lvl(c, k);
    return b;
  endfunction

  task automatic chk(logic [NCH-1:0] got, logic [NCH-1:0] exp, string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s k=%0d actual=%h expected=%h", req, cur_k, got, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = 8'(addr); wr_data = 13'(data);
    @(negedge clk);
    wr_en = 1'b0;
    cur_k++;
  endtask

  task automatic set_tog(int ch, int k, int v);
    wr(ch * 8 + k, v); s_tog[ch][k] = v;
  endtask

  task automatic set_ctrl(int ch, bit pol, bit gate, bit sel);
    wr(ch * 8 + 4, {sel, gate, pol}); s_pol[ch] = pol; s_gate[ch] = gate; s_sel[ch] = sel;
  endtask

  task automatic set_glob(int st, int ln, bit rp);
    wr(NCH * 8 + 0, st); wr(NCH * 8 + 1, ln); wr(NCH * 8 + 2, rp);
    s_start = st; s_len = ln; s_rep = rp;
  endtask

  task automatic new_line();
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
    a_tog = s_tog; a_pol = s_pol; a_gate = s_gate; a_sel = s_sel;
    a_start = s_start; a_len = s_len; a_rep = s_rep;
    cur_k = 0;
  endtask

  // compare the whole bus every cycle up to edge count kt
  task automatic run_to(int kt, string req);
    while (cur_k < kt) begin
      chk(vout, model_bus(cur_k), req);
      @(negedge clk); cur_k++;
    end
    chk(vout, model_bus(cur_k), req);
  endtask

  task automatic clear_all();
    for (int c = 0; c < NCH; c++) begin
      for (int t = 0; t < 4; t++) set_tog(c, t, 0);
      set_ctrl(c, 0, 0, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = $urandom(32'd4711);
    for (int c = 0; c < NCH; c++) begin
      for (int t = 0; t < 4; t++) begin s_tog[c][t] = 0; a_tog[c][t] = 0; end
      s_pol[c] = 0; s_gate[c] = 0; s_sel[c] = 0;
      a_pol[c] = 0; a_gate[c] = 0; a_sel[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(vout, '0, "R1 reset");

    // R1/R7: staged polarity must not show before the first line
    for (int c = 0; c < NCH; c++) set_ctrl(c, 1, 0, 0);
    repeat (4) begin chk(vout, '0, "R1 R7 idle before first sync"); @(negedge clk); end
    new_line();
    chk(vout, '1, "R2 polarity at pixel 0");
    repeat (5) @(negedge clk);
    chk(vout, '1, "R4 all toggles zero keep level");

    // directed: offset, wrap to polarity, repetition
    clear_all();
    set_tog(0, 0, 5); set_tog(0, 1, 10);
    set_tog(1, 0, 5); set_ctrl(1, 1, 0, 0);
    set_glob(3, 20, 1);
    new_line();
    run_to(8, "R3");
    chk(vout[0], 1'b0, "R3 before toggle at offset+5");
    run_to(9, "R2 R3");
    chk(vout[0], 1'b1, "R2 R3 toggle at pixel 8 visible after edge 9");
    run_to(13, "R3");
    chk(vout[0], 1'b1, "R4 held until second toggle");
    run_to(14, "R4");
    chk(vout[0], 1'b0, "R4 second toggle");
    run_to(22, "R5");
    chk(vout[1], 1'b0, "R5 inverted before wrap");
    run_to(23, "R5");
    chk(vout[1], 1'b1, "R5 wrap restores polarity");
    run_to(29, "R5");
    chk(vout[1:0], 2'b01, "R5 second repetition");
    run_to(60, "R5 repeat");

    // directed: gate pairs, duplicates, disabled codes, beyond length
    clear_all();
    set_glob(0, 30, 0);
    for (int c = 2; c <= 3; c++) begin
      set_tog(c, 0, 4); set_tog(c, 1, 6); set_tog(c, 2, 8); set_tog(c, 3, 12);
    end
    set_ctrl(2, 0, 1, 0); set_ctrl(3, 0, 1, 1);
    set_tog(4, 0, 7); set_tog(4, 1, 7);
    set_tog(5, 0, 0); set_tog(5, 1, MAXV); set_tog(5, 2, 0); set_tog(5, 3, MAXV);
    set_ctrl(5, 1, 0, 0);
    set_tog(6, 0, 35);
    // R8: channel 25 is out of range and must not alias onto channel 9
    wr(25 * 8 + 4, 1);
    wr(NCH * 8 + 5, 7);
    new_line();
    run_to(10, "R6");
    chk(vout[3:2], 2'b10, "R6 pair select after pixel 9");
    chk(vout[4], 1'b1, "R10 duplicate toggle inverts once");
    run_to(13, "R6");
    chk(vout[3:2], 2'b00, "R6 both pairs after pixel 12");
    run_to(40, "R4");
    chk(vout[6:5], 2'b01, "R4 disabled codes and beyond-length value ignored");
    chk(vout[9], 1'b0, "R8 out-of-range address ignored");

    // R7 and R9: write mid-line, then restart mid-pattern
    clear_all();
    set_tog(7, 0, 3); set_tog(7, 1, 9);
    set_glob(2, 16, 1);
    new_line();
    run_to(6, "R7");
    set_tog(7, 0, 1); set_ctrl(7, 1, 0, 0); set_glob(0, 12, 0);
    run_to(40, "R7 old config kept mid-line");
    new_line();
    chk(vout[7], 1'b1, "R7 new polarity after next sync");
    run_to(7, "R7 new config");
    new_line();
    run_to(30, "R9 restart mid-pattern");

    // random configurations
    for (int it = 0; it < 25; it++) begin
      for (int c = 0; c < NCH; c++) begin
        for (int t = 0; t < 4; t++) begin
          int r = $urandom % 8;
          set_tog(c, t, (r == 0) ? 0 : (r == 1) ? MAXV : 1 + $urandom % 70);
        end
        set_ctrl(c, 1'($urandom), 1'($urandom % 3 == 0), 1'($urandom));
      end
      set_glob($urandom % 30, ($urandom % 10 == 0) ? 0 : 1 + $urandom % 60, 1'($urandom));
      new_line();
      run_to(150, "R3 R4 R5 R6 R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule